// File: doc/BRIEF.md
# Key-Sequence Lock with Signature Emitter

This block is the protection front end of a memory-copy controller. It watches a narrow key port that carries one nibble per clock, qualified by a valid strobe. A fixed secret sequence of nibbles moves it from the locked state to the open state, which releases the controller it guards. A longer sequence sends it into signature mode instead. That longer sequence is the first part of the same key, then a dedicated signature nibble, then the whole key again. In signature mode the block puts a fixed multi-byte signature on a byte output with a valid strobe, one byte per cycle, without end.

Both terminal states hold until reset, and further key traffic is ignored. Out of reset, and whenever a wrong nibble is seen, the recogniser goes back to its start. The key nibbles, the signature nibble, the signature bytes and all widths are parameters.

Top module: `seqlock_top`

## Requirements
- R1: After reset, `open_o`, `mark_o` and `sig_vld_o` are low, `sig_byte_o` is zero, and the recogniser stands at its first step.
- R2: Key nibble i is `KEY_NIBS[4*i+3:4*i]`, for i = 0 to 7. When these eight nibbles are sampled in order on consecutive valid cycles, `open_o` rises in the cycle after the edge that sampled the last one.
- R3: A sampled nibble that does not match the expected one sends the recogniser back to its first step. If that nibble equals key nibble 0, it counts as the first matched step of a new attempt.
- R4: After key nibbles 0 to 6 have matched, the next sampled nibble decides the path. Key nibble 7 selects the open state, and `SIG_NIB` selects the signature path. Any other value is handled as in R3.
- R5: On the signature path, after `SIG_NIB`, key nibbles 0 to 7 sampled in order make `mark_o` rise in the cycle after the edge that sampled nibble 7. A mismatch on this path is handled as in R3.
- R6: A clock edge with `key_vld_i` low neither advances nor resets the recogniser.
- R7: Once `open_o` or `mark_o` is high, it stays high until reset, and later key traffic has no effect.
- R8: While `mark_o` is high, `sig_vld_o` is high on every cycle, and `sig_byte_o` is `SIG_BYTES[8*j+7:8*j]`. The index j is 0 in the first cycle of the mode, rises by one per cycle, and returns to 0 after 7.
- R9: While `mark_o` is low, `sig_vld_o` is low and `sig_byte_o` is zero. `open_o` and `mark_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| key_nib_i | input | 4 | Key nibble |
| key_vld_i | input | 1 | Key nibble is sampled on this edge |
| open_o | output | 1 | Guarded controller released |
| mark_o | output | 1 | Signature mode active |
| sig_byte_o | output | 8 | Signature byte |
| sig_vld_o | output | 1 | Signature byte write strobe |

## Verification
Signature mode is the hardest state to reach. It needs sixteen correct nibbles in a row, with a branch at the eighth, so uniform random keys would almost never get there. The random stimulus therefore asks the bench model which nibble it expects next and drives that nibble most of the time. At the branch point it picks between the signature nibble and the closing key nibble. It mixes in wrong nibbles, key-nibble-0 restarts and idle cycles, and each episode starts with a reset. Directed runs cover the full signature path, a restart on the final suffix nibble, and more than two turns of the byte index.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
   typedef enum logic [1:0] {
      LK_PRE  = 2'd0,
      LK_SUF  = 2'd1,
      LK_OPEN = 2'd2,
      LK_MARK = 2'd3
   } lk_mode_e;
endpackage

// File: rtl/seqlock_match.sv
module seqlock_match
   import seqlock_pkg::*;
#(
   parameter int          NW       = 4,
   parameter int          KLEN     = 8,
   parameter logic [NW*KLEN-1:0] KEY_NIBS = '0,
   parameter logic [NW-1:0] SIG_NIB  = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NW-1:0] nib_i,
   input  logic          vld_i,
   output lk_mode_e      mode_o
);
   localparam int IW = (KLEN > 1) ? $clog2(KLEN) : 1;
   localparam logic [IW-1:0] LAST = IW'(KLEN - 1);

   logic [NW-1:0] key_a [KLEN];
   for (genvar g = 0; g < KLEN; g++) begin : g_key
      assign key_a[g] = KEY_NIBS[g*NW +: NW];
   end

   lk_mode_e      mode_q, mode_d;
   logic [IW-1:0] cnt_q, cnt_d;
   logic          hit, restart_one;

   assign hit         = (nib_i == key_a[cnt_q]);
   assign restart_one = (nib_i == key_a[0]);

   always_comb begin
      mode_d = mode_q;
      cnt_d  = cnt_q;
      if (vld_i) begin
         unique case (mode_q)
            LK_PRE: begin
               if (cnt_q == LAST) begin
                  if (hit) begin
                     mode_d = LK_OPEN;
                     cnt_d  = '0;
                  end else if (nib_i == SIG_NIB) begin
                     mode_d = LK_SUF;
                     cnt_d  = '0;
                  end else begin
                     mode_d = LK_PRE;
                     cnt_d  = restart_one ? IW'(1) : '0;
                  end
               end else if (hit) begin
                  cnt_d = cnt_q + IW'(1);
               end else begin
                  cnt_d = restart_one ? IW'(1) : '0;
               end
            end
            LK_SUF: begin
               if (hit) begin
                  if (cnt_q == LAST) begin
                     mode_d = LK_MARK;
                     cnt_d  = '0;
                  end else begin
                     cnt_d = cnt_q + IW'(1);
                  end
               end else begin
                  mode_d = LK_PRE;
                  cnt_d  = restart_one ? IW'(1) : '0;
               end
            end
            default: begin
               mode_d = mode_q;
               cnt_d  = cnt_q;
            end
         endcase
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         mode_q <= LK_PRE;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_d;
         cnt_q  <= cnt_d;
      end
   end

   assign mode_o = mode_q;

   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> ($stable(mode_q) && $stable(cnt_q)));
   a_r7_open_sticky: assert property (@(posedge clk) disable iff (rst)
      (mode_q == LK_OPEN) |=> (mode_q == LK_OPEN));
   a_r7_mark_sticky: assert property (@(posedge clk) disable iff (rst)
      (mode_q == LK_MARK) |=> (mode_q == LK_MARK));
endmodule

// File: rtl/seqlock_emit.sv
module seqlock_emit #(
   parameter int BW     = 8,
   parameter int NBYTES = 8,
   parameter logic [BW*NBYTES-1:0] SIG_BYTES = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          active_i,
   output logic [BW-1:0] byte_o,
   output logic          vld_o
);
   localparam int XW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
   localparam logic [XW-1:0] LAST = XW'(NBYTES - 1);

   logic [BW-1:0] sig_a [NBYTES];
   for (genvar g = 0; g < NBYTES; g++) begin : g_sig
      assign sig_a[g] = SIG_BYTES[g*BW +: BW];
   end

   logic [XW-1:0] idx_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         idx_q <= '0;
      end else if (active_i) begin
         idx_q <= (idx_q == LAST) ? '0 : idx_q + XW'(1);
      end
   end

   assign byte_o = active_i ? sig_a[idx_q] : '0;
   assign vld_o  = active_i;

   a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
      (active_i && idx_q == LAST) |=> (idx_q == '0));
   a_r8_step: assert property (@(posedge clk) disable iff (rst)
      (active_i && idx_q != LAST) |=> (idx_q == $past(idx_q) + XW'(1)));
endmodule

// File: rtl/seqlock_top.sv
module seqlock_top
   import seqlock_pkg::*;
#(
   parameter int NW     = 4,
   parameter int KLEN   = 8,
   parameter int BW     = 8,
   parameter int NBYTES = 8,
   parameter logic [NW*KLEN-1:0]   KEY_NIBS  = 32'hC3A1_7E26,
   parameter logic [NW-1:0]        SIG_NIB   = 4'hB,
   parameter logic [BW*NBYTES-1:0] SIG_BYTES = 64'h5A3C_96E1_0FF0_A55A
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [NW-1:0] key_nib_i,
   input  logic          key_vld_i,
   output logic          open_o,
   output logic          mark_o,
   output logic [BW-1:0] sig_byte_o,
   output logic          sig_vld_o
);
   if (KLEN < 2) begin : g_bad_len
      $error("seqlock_top: KLEN must be at least 2");
   end
   if (NBYTES < 2) begin : g_bad_bytes
      $error("seqlock_top: NBYTES must be at least 2");
   end
   if (SIG_NIB == KEY_NIBS[(KLEN-1)*NW +: NW]) begin : g_bad_branch
      $error("seqlock_top: SIG_NIB must differ from the last key nibble");
   end

   lk_mode_e mode;

   seqlock_match #(
      .NW(NW), .KLEN(KLEN), .KEY_NIBS(KEY_NIBS), .SIG_NIB(SIG_NIB)
   ) match_i (
      .clk(clk), .rst(rst), .nib_i(key_nib_i), .vld_i(key_vld_i), .mode_o(mode)
   );

   assign open_o = (mode == LK_OPEN);
   assign mark_o = (mode == LK_MARK);

   seqlock_emit #(
      .BW(BW), .NBYTES(NBYTES), .SIG_BYTES(SIG_BYTES)
   ) emit_i (
      .clk(clk), .rst(rst), .active_i(mark_o), .byte_o(sig_byte_o), .vld_o(sig_vld_o)
   );

   a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(open_o && mark_o));
   a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
      !mark_o |-> (!sig_vld_o && sig_byte_o == '0));
endmodule

// File: tb/seqlock_top_tb_top.sv
module seqlock_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] KEYS = 32'hC3A1_7E26;
   localparam logic [3:0]  SNIB = 4'hB;
   localparam logic [63:0] SIGB = 64'h5A3C_96E1_0FF0_A55A;

   logic clk = 0, rst = 1;
   logic [3:0] key_nib = 0;
   logic key_vld = 0;
   logic open_w, mark_w, svld_w;
   logic [7:0] sbyte_w;
   int n_run = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqlock_top #(.KEY_NIBS(KEYS), .SIG_NIB(SNIB), .SIG_BYTES(SIGB)) dut_i (
      .clk(clk), .rst(rst), .key_nib_i(key_nib), .key_vld_i(key_vld),
      .open_o(open_w), .mark_o(mark_w), .sig_byte_o(sbyte_w), .sig_vld_o(svld_w));

   // model: 0 pre, 1 suffix, 2 open, 3 mark
   int m_mode = 0, m_cnt = 0, m_idx = 0;

   function automatic logic [3:0] kn(int i);
      return KEYS[4*i +: 4];
   endfunction

   function automatic logic [7:0] sb(int j);
      return SIGB[8*j +: 8];
   endfunction

   task automatic restart(logic [3:0] k);
      m_mode = 0;
      m_cnt = (k == kn(0)) ? 1 : 0;
   endtask

   task automatic model_edge(logic v, logic [3:0] k);
      if (m_mode == 3) m_idx = (m_idx + 1) % 8;
      if (!v) return;
      case (m_mode)
         0: if (m_cnt == 7) begin
               if (k == kn(7)) begin m_mode = 2; m_cnt = 0; end
               else if (k == SNIB) begin m_mode = 1; m_cnt = 0; end
               else restart(k);
            end else if (k == kn(m_cnt)) m_cnt++;
            else restart(k);
         1: if (k == kn(m_cnt)) begin
               if (m_cnt == 7) begin m_mode = 3; m_cnt = 0; end
               else m_cnt++;
            end else restart(k);
         default: ;
      endcase
   endtask

   task automatic check(string tag);
      logic e_open, e_mark;
      logic [7:0] e_byte;
      e_open = (m_mode == 2);
      e_mark = (m_mode == 3);
      e_byte = e_mark ? sb(m_idx) : 8'h00;
      n_run++;
      if (open_w !== e_open || mark_w !== e_mark || svld_w !== e_mark || sbyte_w !== e_byte) begin
         n_fail++;
         $display("FAIL %s: got open=%b mark=%b vld=%b byte=%h, exp open=%b mark=%b vld=%b byte=%h",
                  tag, open_w, mark_w, svld_w, sbyte_w, e_open, e_mark, e_mark, e_byte);
      end
   endtask

   task automatic step(logic v, logic [3:0] k, string tag);
      key_vld = v;
      key_nib = k;
      @(posedge clk);
      model_edge(v, k);
      @(negedge clk);
      check(tag);
   endtask

   task automatic do_reset();
      rst = 1; key_vld = 0; key_nib = 0;
      m_mode = 0; m_cnt = 0; m_idx = 0;
      @(negedge clk); @(negedge clk);
      rst = 0;
      @(negedge clk);
      check("R1 reset state");
   endtask

   task automatic send_prefix(int n, string tag);
      for (int i = 0; i < n; i++) step(1, kn(i), tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int r;
      logic [3:0] k;
      void'($urandom(32'd1234));
      // R1 and R2: plain unlock
      do_reset();
      send_prefix(8, "R2 unlock path");
      // R7: traffic after open ignored
      send_prefix(7, "R7 open sticky");
      step(1, SNIB, "R7 open sticky");
      // R5 and R8: signature path with long run
      do_reset();
      send_prefix(7, "R5 prefix");
      step(1, SNIB, "R4 branch to signature");
      send_prefix(8, "R5 suffix");
      for (int i = 0; i < 20; i++) step(i % 3 == 0, kn(0), "R8 signature stream");
      // R4: other value at branch, equal to key nibble 0
      do_reset();
      send_prefix(7, "R4 prefix");
      step(1, kn(0), "R4 other at branch");
      send_prefix(7, "R3 restart counted");
      step(1, kn(7), "R3 restart counted");
      // R3: mismatch on last suffix nibble
      do_reset();
      send_prefix(7, "R5 prefix");
      step(1, SNIB, "R5 branch");
      send_prefix(7, "R5 suffix");
      step(1, 4'hF, "R3 suffix mismatch");
      step(1, kn(7), "R3 no stale progress");
      // R6: idle cycles interleaved
      do_reset();
      for (int i = 0; i < 8; i++) begin
         step(0, 4'hF, "R6 idle gap");
         step(0, kn(0), "R6 idle gap");
         step(1, kn(i), "R6 unlock across gaps");
      end
      // R9: locked outputs under garbage
      do_reset();
      for (int i = 0; i < 10; i++) step(1, 4'(i), "R9 quiet while locked");
      // random episodes
      for (int ep = 0; ep < 60; ep++) begin
         do_reset();
         for (int c = 0; c < 50; c++) begin
            r = $urandom_range(0, 99);
            if (m_mode < 2 && r < 75) begin
               if (m_mode == 0 && m_cnt == 7 && r < 40) k = SNIB;
               else k = kn(m_cnt);
            end else if (r < 85) k = kn(0);
            else k = 4'($urandom_range(0, 15));
            step($urandom_range(0, 4) != 0, k, "R2 R3 R4 R5 R8 random");
         end
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule